// File: doc/BRIEF.md
# Dual-Channel Serial Result Shifter

This block models the device side of the serial output of a two-channel sampling converter. A falling edge on the conversion-start input starts a conversion of fixed length, counted in system clocks. The busy flag stays high for that time. When the conversion ends, the block captures both 12-bit results from its inputs and drops busy. A host then reads the results over a chip-select and serial-clock interface. Each channel has its own data line, and each line has its own drive-enable that stands in for a three-state pin.

All interface inputs are sampled on the system clock and edge-detected, so every response takes a short, fixed number of system clocks. Each line sends its own word first and then the other channel's word. This lets a host read both results through a single line. A host can lower chip-select during a conversion and get the MSB as busy falls. It can also hold chip-select low for good and run in a continuous stream mode.

Top module: `dual_result_shifter`

## Requirements
- R1: Within two clocks of a falling edge on `conv_start_n`, `busy` rises. It then stays high for exactly `CONV_CYCLES` clocks.
- R2: A further falling edge on `conv_start_n` while `busy` is high is ignored. The conversion still lasts exactly `CONV_CYCLES` clocks.
- R3: Within two clocks of a falling edge on `cs_n`, both enables go high and each line presents bit 11 (the MSB) of its own word.
- R4: With `cs_n` low and `busy` low, each counted falling edge of `sclk` moves both lines one bit toward the LSB, MSB first.
- R5: While `cs_n` is high, both enables are low. This includes the state after reset.
- R6: After 12 counted `sclk` falling edges, `dout_a` carries word B and `dout_b` carries word A, again MSB first. The full sequence is A then B on `dout_a`, and B then A on `dout_b`.
- R7: After 23 counted falling edges, each line holds bit 0 of its second word. Further falling edges leave it there until `cs_n` rises.
- R8: An `sclk` falling edge that is sampled in the same clock as the `cs_n` falling edge is not counted. The next `sclk` falling edge moves the lines to bit 10.
- R9: If `cs_n` falls while `busy` is high, the enables rise at once. `sclk` falling edges during `busy` are not counted. Once `busy` falls, both lines present the MSB of the new results.
- R10: With `cs_n` held low across conversions, the enables never drop. The new MSB appears as `busy` falls, and the next bit appears on the next `sclk` falling edge.
- R11: Results are captured from `res_a`/`res_b` only when a conversion ends. Later changes on those inputs do not appear on the lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start_n | input | 1 | Conversion start; a falling edge starts a conversion |
| cs_n | input | 1 | Active-low chip-select |
| sclk | input | 1 | Serial clock; its falling edges advance the data |
| res_a | input | WORD_W | Channel A result, captured at end of conversion |
| res_b | input | WORD_W | Channel B result, captured at end of conversion |
| busy | output | 1 | High while a conversion is in progress |
| dout_a | output | 1 | Serial data line A |
| dout_a_en | output | 1 | Drive enable of line A (low means high impedance) |
| dout_b | output | 1 | Serial data line B |
| dout_b_en | output | 1 | Drive enable of line B (low means high impedance) |

## Verification
The hardest case to reach from the ports is a chip-select falling edge that lands during a conversion, followed by serial-clock activity that must not count. Only after busy falls may the MSB of the freshly captured words appear. The stimulus lowers `cs_n` two clocks after the start pulse and issues one full `sclk` pulse while `busy` is known to still be high. It then waits for busy to fall and checks that the MSB and then bit 10 come out. This shows the stray edge was discarded and the index was restarted by the load. The coincident-edge case is reached by driving `cs_n` and `sclk` low on the same clock, so both falls are sampled together.

// File: rtl/dres_pkg.sv
package dres_pkg;

    localparam int DEF_WORD_W      = 12;
    localparam int DEF_CONV_CYCLES = 20;
    localparam int NUM_LANES       = 2;
    localparam int NUM_PINS        = 3;

    // sampled pin order inside the sampler
    localparam int PIN_CONV = 0;
    localparam int PIN_CS   = 1;
    localparam int PIN_SCLK = 2;

    typedef struct packed {
        logic conv_fall;
        logic cs_fall;
        logic cs_low;
        logic sclk_fall;
    } pin_evt_t;

    typedef enum logic {
        CONV_IDLE,
        CONV_RUN
    } conv_state_e;

endpackage

// File: rtl/pin_sampler.sv
module pin_sampler
    import dres_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     conv_start_n,
    input  logic     cs_n,
    input  logic     sclk,
    output pin_evt_t evt
);

    logic [NUM_PINS-1:0] pins;
    logic [NUM_PINS-1:0] cur_q;
    logic [NUM_PINS-1:0] prev_q;
    logic [NUM_PINS-1:0] fall;

    assign pins[PIN_CONV] = conv_start_n;
    assign pins[PIN_CS]   = cs_n;
    assign pins[PIN_SCLK] = sclk;

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q  <= '1;
            prev_q <= '1;
        end else begin
            cur_q  <= pins;
            prev_q <= cur_q;
        end
    end

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_edge
        assign fall[p] = prev_q[p] & ~cur_q[p];
    end

    assign evt.conv_fall = fall[PIN_CONV];
    assign evt.cs_fall   = fall[PIN_CS];
    assign evt.cs_low    = ~cur_q[PIN_CS];
    assign evt.sclk_fall = fall[PIN_SCLK];

endmodule

// File: rtl/conv_timer.sv
module conv_timer
    import dres_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int CONV_CYCLES = DEF_CONV_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_fall,
    input  logic [WORD_W-1:0] in_a,
    input  logic [WORD_W-1:0] in_b,
    output logic              busy,
    output logic              load,
    output logic [WORD_W-1:0] word_a,
    output logic [WORD_W-1:0] word_b
);

    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    conv_state_e      state;
    logic [CNT_W-1:0] remain;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= CONV_IDLE;
            remain <= '0;
            load   <= 1'b0;
            word_a <= '0;
            word_b <= '0;
        end else begin
            load <= 1'b0;
            case (state)
                CONV_IDLE: begin
                    if (start_fall) begin
                        state  <= CONV_RUN;
                        remain <= CNT_W'(CONV_CYCLES - 1);
                    end
                end
                CONV_RUN: begin
                    if (remain == '0) begin
                        state  <= CONV_IDLE;
                        word_a <= in_a;
                        word_b <= in_b;
                        load   <= 1'b1;
                    end else begin
                        remain <= remain - 1'b1;
                    end
                end
                default: state <= CONV_IDLE;
            endcase
        end
    end

    assign busy = (state == CONV_RUN);

    // R1
    busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && remain != '0) |=> busy);

    // R2
    restart_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start_fall && remain != '0) |=> (busy && remain == $past(remain) - 1'b1));

    // R11
    words_held_chk: assert property (@(posedge clk) disable iff (rst)
        !load |-> ($stable(word_a) && $stable(word_b)));

endmodule

// File: rtl/bit_sequencer.sv
module bit_sequencer
    import dres_pkg::*;
#(
    parameter int WORD_W = DEF_WORD_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  pin_evt_t             evt,
    input  logic                 busy,
    input  logic                 load,
    input  logic [WORD_W-1:0]    word_a,
    input  logic [WORD_W-1:0]    word_b,
    output logic [NUM_LANES-1:0] dout,
    output logic [NUM_LANES-1:0] dout_en
);

    localparam int STREAM_W = 2 * WORD_W;
    localparam int IDX_W    = $clog2(STREAM_W);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(STREAM_W - 1);

    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] sel;
    logic             advance;

    assign advance = evt.cs_low && evt.sclk_fall && !busy && (idx != LAST_IDX);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx <= '0;
        end else if (load || evt.cs_fall) begin
            idx <= '0;
        end else if (advance) begin
            idx <= idx + 1'b1;
        end
    end

    assign sel = LAST_IDX - idx;

    for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane
        logic [STREAM_W-1:0] stream;
        if (l == 0) begin : g_own_a
            assign stream = {word_a, word_b};
        end else begin : g_own_b
            assign stream = {word_b, word_a};
        end
        assign dout[l]    = stream[sel];
        assign dout_en[l] = evt.cs_low;
    end

    // R8
    cs_fall_restart_chk: assert property (@(posedge clk) disable iff (rst)
        evt.cs_fall |=> (idx == '0));

    // R4
    step_chk: assert property (@(posedge clk) disable iff (rst)
        (evt.cs_low && evt.sclk_fall && !evt.cs_fall && !busy && !load && idx != LAST_IDX)
            |=> (idx == $past(idx) + 1'b1));

    // R7
    last_bit_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (idx == LAST_IDX && !evt.cs_fall && !load) |=> (idx == LAST_IDX));

    // R9
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && !evt.cs_fall && !load) |=> $stable(idx));

endmodule

// File: rtl/dual_result_shifter.sv
module dual_result_shifter
    import dres_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int CONV_CYCLES = DEF_CONV_CYCLES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              conv_start_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic [WORD_W-1:0] res_a,
    input  logic [WORD_W-1:0] res_b,
    output logic              busy,
    output logic              dout_a,
    output logic              dout_a_en,
    output logic              dout_b,
    output logic              dout_b_en
);

    pin_evt_t              evt;
    logic                  load;
    logic [WORD_W-1:0]     word_a;
    logic [WORD_W-1:0]     word_b;
    logic [NUM_LANES-1:0]  dout;
    logic [NUM_LANES-1:0]  dout_en;

    pin_sampler u_sampler (
        .clk          (clk),
        .rst          (rst),
        .conv_start_n (conv_start_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .evt          (evt)
    );

    conv_timer #(
        .WORD_W      (WORD_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_timer (
        .clk        (clk),
        .rst        (rst),
        .start_fall (evt.conv_fall),
        .in_a       (res_a),
        .in_b       (res_b),
        .busy       (busy),
        .load       (load),
        .word_a     (word_a),
        .word_b     (word_b)
    );

    bit_sequencer #(
        .WORD_W (WORD_W)
    ) u_seq (
        .clk     (clk),
        .rst     (rst),
        .evt     (evt),
        .busy    (busy),
        .load    (load),
        .word_a  (word_a),
        .word_b  (word_b),
        .dout    (dout),
        .dout_en (dout_en)
    );

    assign dout_a    = dout[0];
    assign dout_b    = dout[1];
    assign dout_a_en = dout_en[0];
    assign dout_b_en = dout_en[1];

    // R3
    enable_on_select_chk: assert property (@(posedge clk) disable iff (rst)
        evt.cs_fall |-> (dout_a_en && dout_b_en));

    // R5
    release_on_deselect_chk: assert property (@(posedge clk) disable iff (rst)
        !evt.cs_low |-> (!dout_a_en && !dout_b_en));

endmodule

// File: tb/dual_result_shifter_tb.sv
module dual_result_shifter_tb;

    localparam int CLK_PERIOD  = 10;
    localparam int WORD_W      = 12;
    localparam int CONV_CYCLES = 20;

    logic              clk = 1'b0;
    logic              rst;
    logic              conv_start_n;
    logic              cs_n;
    logic              sclk;
    logic [WORD_W-1:0] res_a;
    logic [WORD_W-1:0] res_b;
    logic              busy;
    logic              dout_a;
    logic              dout_a_en;
    logic              dout_b;
    logic              dout_b_en;

    int vecs = 0;
    int errs = 0;
    int en_drops = 0;
    bit cont_mon = 1'b0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_result_shifter #(
        .WORD_W      (WORD_W),
        .CONV_CYCLES (CONV_CYCLES)
    ) u_dut (
        .clk          (clk),
        .rst          (rst),
        .conv_start_n (conv_start_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .res_a        (res_a),
        .res_b        (res_b),
        .busy         (busy),
        .dout_a       (dout_a),
        .dout_a_en    (dout_a_en),
        .dout_b       (dout_b),
        .dout_b_en    (dout_b_en)
    );

    always @(negedge clk) begin
        if (cont_mon && (!dout_a_en || !dout_b_en)) en_drops++;
    end

    task automatic chk(input string req, input int act, input int exp);
        vecs++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic exp_bit(input logic [WORD_W-1:0] own,
                                     input logic [WORD_W-1:0] other, input int k);
        int kk = (k > 2*WORD_W-1) ? 2*WORD_W-1 : k;
        return (kk < WORD_W) ? own[WORD_W-1-kk] : other[2*WORD_W-1-kk];
    endfunction

    task automatic check_lines(input string req, input logic [WORD_W-1:0] a,
                               input logic [WORD_W-1:0] b, input int k);
        chk(req, int'(dout_a), int'(exp_bit(a, b, k)));
        chk(req, int'(dout_b), int'(exp_bit(b, a, k)));
    endtask

    task automatic sclk_pulse();
        sclk = 1'b0;
        settle(3);
        sclk = 1'b1;
        settle(2);
    endtask

    task automatic convert(input logic [WORD_W-1:0] a, input logic [WORD_W-1:0] b,
                           input bit restart, output int busy_len);
        busy_len = 0;
        res_a = a;
        res_b = b;
        conv_start_n = 1'b0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (i == 2) conv_start_n = 1'b1;
            if (restart && i == 8) conv_start_n = 1'b0;
            if (restart && i == 10) conv_start_n = 1'b1;
            if (busy) busy_len++;
            else if (busy_len > 0) break;
        end
        conv_start_n = 1'b1;
        res_a = ~a;   // R11: inputs move after capture
        res_b = ~b;
    endtask

    task automatic t_reset();
        chk("R1 busy after reset", int'(busy), 0);
        chk("R5 enable A after reset", int'(dout_a_en), 0);
        chk("R5 enable B after reset", int'(dout_b_en), 0);
    endtask

    task automatic t_conversion();
        int len;
        convert(12'hA5C, 12'h3E1, 1'b0, len);
        chk("R1 busy length", len, CONV_CYCLES);
        convert(12'hA5C, 12'h3E1, 1'b1, len);
        chk("R2 busy length with restart", len, CONV_CYCLES);
    endtask

    task automatic t_read_word();
        sclk_pulse();   // deselected edges: nothing visible
        chk("R5 enable A while deselected", int'(dout_a_en), 0);
        cs_n = 1'b0;
        settle(2);
        chk("R3 enable A", int'(dout_a_en), 1);
        chk("R3 enable B", int'(dout_b_en), 1);
        check_lines("R3 MSB", 12'hA5C, 12'h3E1, 0);
        for (int k = 1; k < WORD_W; k++) begin
            sclk_pulse();
            check_lines("R4 shift", 12'hA5C, 12'h3E1, k);
        end
        cs_n = 1'b1;
        settle(2);
        chk("R5 enable A released", int'(dout_a_en), 0);
        chk("R5 enable B released", int'(dout_b_en), 0);
    endtask

    task automatic t_chain();
        int len;
        convert(12'h9B4, 12'h16D, 1'b0, len);
        cs_n = 1'b0;
        settle(2);
        check_lines("R3 MSB chain", 12'h9B4, 12'h16D, 0);
        for (int k = 1; k < 2*WORD_W; k++) begin
            sclk_pulse();
            if (k < WORD_W) check_lines("R4 first word", 12'h9B4, 12'h16D, k);
            else            check_lines("R6 second word", 12'h9B4, 12'h16D, k);
        end
        for (int e = 0; e < 3; e++) begin
            sclk_pulse();
            check_lines("R7 hold last bit", 12'h9B4, 12'h16D, 2*WORD_W-1);
        end
        cs_n = 1'b1;
        settle(2);
    endtask

    task automatic t_coincident();
        cs_n = 1'b0;
        sclk = 1'b0;
        settle(3);
        check_lines("R8 coincident edge ignored", 12'h9B4, 12'h16D, 0);
        sclk = 1'b1;
        settle(2);
        sclk_pulse();
        check_lines("R8 next edge counted", 12'h9B4, 12'h16D, 1);
        cs_n = 1'b1;
        settle(2);
    endtask

    task automatic t_early_select();
        int guard = 0;
        res_a = 12'hC37;
        res_b = 12'h4A8;
        conv_start_n = 1'b0;
        settle(2);
        conv_start_n = 1'b1;
        cs_n = 1'b0;
        settle(2);
        chk("R9 busy during early select", int'(busy), 1);
        chk("R9 enable A during busy", int'(dout_a_en), 1);
        chk("R9 enable B during busy", int'(dout_b_en), 1);
        sclk_pulse();
        chk("R9 still busy after stray edge", int'(busy), 1);
        while (busy && guard < 200) begin
            @(negedge clk);
            guard++;
        end
        res_a = 12'h000;
        res_b = 12'hFFF;
        settle(2);
        check_lines("R9 MSB after busy falls", 12'hC37, 12'h4A8, 0);
        sclk_pulse();
        check_lines("R9 busy edge not counted", 12'hC37, 12'h4A8, 1);
        cs_n = 1'b1;
        settle(2);
    endtask

    task automatic t_continuous();
        int len;
        cs_n = 1'b0;
        settle(2);
        cont_mon = 1'b1;
        convert(12'h5F0, 12'hB29, 1'b0, len);
        settle(2);
        check_lines("R10 MSB first conversion", 12'h5F0, 12'hB29, 0);
        sclk_pulse();
        check_lines("R10 next bit first conversion", 12'h5F0, 12'hB29, 1);
        convert(12'h2D7, 12'hE86, 1'b0, len);
        settle(2);
        check_lines("R10 MSB second conversion", 12'h2D7, 12'hE86, 0);
        sclk_pulse();
        check_lines("R10 next bit second conversion", 12'h2D7, 12'hE86, 1);
        cont_mon = 1'b0;
        chk("R10 enable drops", en_drops, 0);
        cs_n = 1'b1;
        settle(2);
    endtask

    task automatic t_capture();
        // inputs now hold the complement of the last captured words
        cs_n = 1'b0;
        settle(2);
        for (int k = 0; k < 4; k++) begin
            if (k > 0) sclk_pulse();
            check_lines("R11 captured words kept", 12'h2D7, 12'hE86, k);
        end
        cs_n = 1'b1;
        settle(2);
    endtask

    initial begin
        rst = 1'b1;
        conv_start_n = 1'b1;
        cs_n = 1'b1;
        sclk = 1'b1;
        res_a = '0;
        res_b = '0;
        settle(3);
        rst = 1'b0;
        settle(2);
        t_reset();
        t_conversion();
        t_read_word();
        t_chain();
        t_coincident();
        t_early_select();
        t_continuous();
        t_capture();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            finished = 1'b1;
            vecs++;
            errs++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
            $finish;
        end
    end

endmodule